// File: doc/BRIEF.md
# I2C Slave Transmit Request Handler

This block sequences the slave-transmitter half of an I2C controller. Once the address stage reports that a remote master has addressed this device for a read, the handler feeds bytes from the transmit FIFO to the slave bit engine, one byte per acknowledge cycle. When the engine needs a byte and the FIFO is empty, the handler raises a read-request flag for software and asks the bit engine to stretch the clock until data arrives.

The handler also cleans up around the transfer. Data left in the FIFO when a new read begins is flushed with an abort. A FIFO entry whose command bit marks a read is rejected with an abort. A bus-level mismatch between the driven and the sampled data aborts the transfer. A NACK from the master ends the transfer normally and throws away any surplus bytes. A STOP or repeated START ends it silently. Address matching, bit timing and FIFO storage sit outside the block.

Top module: `stx_slave_tx`

## Requirements
- R1: After reset, scl_hold_o, rd_req_o, busy_o, fifo_pop_o, fifo_flush_o, load_valid_o, done_o and abort_o are all 0.
- R2: In a transfer, when a byte is needed and fifo_level_i is 0, scl_hold_o is 1 in that same cycle and rd_req_o is 1 from the following cycle. Neither depends on rd_req_clr_i.
- R3: rd_req_o stays 1 until a cycle with rd_req_clr_i high. Writing data into the FIFO does not clear it.
- R4: When a byte is needed, fifo_level_i is non-zero and fifo_cmd_i is 0, fifo_pop_o and load_valid_o are 1 in the same cycle, and load_data_o equals fifo_data_i. Bytes the master ACKs are followed by the next FIFO byte with no new read request and no clock hold. Bytes go out in FIFO order.
- R5: If rd_hit_i arrives while fifo_level_i is non-zero, the FIFO is flushed and abort_o pulses with abort_cause_o = 4'b0001 (bit 0: stale data flushed). The transfer continues and then asks for new data.
- R6: A byte ended with master_nack_i = 1 produces a one-cycle done_o, flushes any remaining FIFO entries, and returns the block to idle (busy_o = 0).
- R7: A needed FIFO entry with fifo_cmd_i = 1 is not loaded. Instead, abort_o pulses with abort_cause_o = 4'b0010 (bit 1: read command in transmit data), the FIFO is flushed and the block goes idle.
- R8: While a byte is being sent, if scl_rise_i is high and sda_drive_i differs from sda_in_i, abort_o pulses with abort_cause_o = 4'b1100 (bit 2: slave lost the bus, bit 3: arbitration lost), the FIFO is flushed and the block goes idle. A matching bit has no effect.
- R9: bus_end_i (STOP or repeated START) during a transfer flushes the FIFO and returns the block to idle with neither done_o nor abort_o.
- R10: done_o and abort_o appear in the cycle after the edge at which the condition is taken, and each lasts one cycle. abort_cause_o is non-zero only together with abort_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_hit_i | input | 1 | Pulse: this device is addressed for a read |
| fifo_level_i | input | LVL_W | Number of entries in the transmit FIFO |
| fifo_data_i | input | DATA_W | Data field of the FIFO head entry |
| fifo_cmd_i | input | 1 | Command bit of the FIFO head entry (1 = read) |
| byte_done_i | input | 1 | Pulse: the bit engine finished a byte and its acknowledge |
| master_nack_i | input | 1 | Acknowledge value with byte_done_i (1 = NACK) |
| bus_end_i | input | 1 | Pulse: STOP or repeated START seen on the bus |
| scl_rise_i | input | 1 | Pulse: rising SCL edge while sending |
| sda_drive_i | input | 1 | SDA value the engine is driving |
| sda_in_i | input | 1 | SDA value sampled from the bus |
| rd_req_clr_i | input | 1 | Software clear of the read request |
| scl_hold_o | output | 1 | Ask the engine to hold SCL low |
| fifo_pop_o | output | 1 | Remove the FIFO head entry |
| fifo_flush_o | output | 1 | Empty the FIFO |
| load_valid_o | output | 1 | A byte is handed to the bit engine |
| load_data_o | output | DATA_W | Byte handed to the bit engine |
| rd_req_o | output | 1 | Read-request flag for software |
| done_o | output | 1 | Pulse: transfer ended by master NACK |
| abort_o | output | 1 | Pulse: transmit abort |
| abort_cause_o | output | 4 | Abort cause bits, valid with abort_o |
| busy_o | output | 1 | Transfer in progress (SDA/SCL owned) |

## Verification
The bench first fills the FIFO before an addressed read. A handler that skipped the stale-data flush would send the old byte instead of raising the abort and a read request. It also sends several bytes in a row with ACKs, then NACKs a byte while surplus entries wait. A handler that re-requested on every byte would stretch the clock needlessly, and one that skipped the final flush would leave the surplus bytes for the next read. It also presents a head entry with the command bit set, plus a matching and a mismatching SDA sample. A handler that loaded the command entry, or aborted on a clean bit, would show up at load_valid_o and abort_o. A STOP in mid-byte is checked to end the transfer without a done pulse.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NEED = 2'd1,
    ST_SEND = 2'd2
  } stx_state_e;

  localparam int CAUSE_W      = 4;
  localparam int CZ_STALE     = 0;
  localparam int CZ_RDCMD     = 1;
  localparam int CZ_SLV_LOST  = 2;
  localparam int CZ_ARB_LOST  = 3;
endpackage

// File: rtl/stx_ctrl_fsm.sv
module stx_ctrl_fsm
  import stx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic              fifo_cmd_i,
  input  logic              byte_done_i,
  input  logic              master_nack_i,
  input  logic              bus_end_i,
  input  logic              scl_rise_i,
  input  logic              sda_drive_i,
  input  logic              sda_in_i,
  output logic              scl_hold_o,
  output logic              req_set_o,
  output logic              fifo_pop_o,
  output logic              fifo_flush_o,
  output logic              load_valid_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              done_evt_o,
  output logic              abort_evt_o,
  output logic [CAUSE_W-1:0] cause_evt_o,
  output logic              busy_o
);
  stx_state_e st_q, st_nxt;
  logic       st_en;
  logic       fifo_empty;

  assign fifo_empty  = (fifo_level_i == '0);
  assign load_data_o = fifo_data_i;
  assign busy_o      = (st_q != ST_IDLE);

  // next-state and output decode
  always_comb begin
    st_nxt       = st_q;
    scl_hold_o   = 1'b0;
    req_set_o    = 1'b0;
    fifo_pop_o   = 1'b0;
    fifo_flush_o = 1'b0;
    load_valid_o = 1'b0;
    done_evt_o   = 1'b0;
    abort_evt_o  = 1'b0;
    cause_evt_o  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (rd_hit_i) begin
          st_nxt = ST_NEED;
          if (!fifo_empty) begin
            fifo_flush_o          = 1'b1;
            abort_evt_o           = 1'b1;
            cause_evt_o[CZ_STALE] = 1'b1;
          end
        end
      end
      ST_NEED: begin
        if (bus_end_i) begin
          fifo_flush_o = 1'b1;
          st_nxt       = ST_IDLE;
        end else if (fifo_empty) begin
          scl_hold_o = 1'b1;
          req_set_o  = 1'b1;
        end else if (fifo_cmd_i) begin
          fifo_flush_o          = 1'b1;
          abort_evt_o           = 1'b1;
          cause_evt_o[CZ_RDCMD] = 1'b1;
          st_nxt                = ST_IDLE;
        end else begin
          fifo_pop_o   = 1'b1;
          load_valid_o = 1'b1;
          st_nxt       = ST_SEND;
        end
      end
      ST_SEND: begin
        if (scl_rise_i && (sda_drive_i != sda_in_i)) begin
          fifo_flush_o             = 1'b1;
          abort_evt_o              = 1'b1;
          cause_evt_o[CZ_SLV_LOST] = 1'b1;
          cause_evt_o[CZ_ARB_LOST] = 1'b1;
          st_nxt                   = ST_IDLE;
        end else if (bus_end_i) begin
          fifo_flush_o = 1'b1;
          st_nxt       = ST_IDLE;
        end else if (byte_done_i) begin
          if (master_nack_i) begin
            done_evt_o   = 1'b1;
            fifo_flush_o = 1'b1;
            st_nxt       = ST_IDLE;
          end else begin
            st_nxt = ST_NEED;
          end
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign st_en = (st_nxt != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (st_en) begin
      st_q <= st_nxt;
    end
  end

  p_pop_flush_excl_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_pop_o && fifo_flush_o));

  p_load_then_send_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    load_valid_o |=> (st_q == ST_SEND));
endmodule

// File: rtl/stx_req_flag.sv
module stx_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  logic req_nxt;
  logic req_en;

  // a pending set wins over a clear in the same cycle
  always_comb begin
    req_nxt = req_o;
    if (clr_i) req_nxt = 1'b0;
    if (set_i) req_nxt = 1'b1;
  end

  assign req_en = set_i | clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o <= 1'b0;
    end else if (req_en) begin
      req_o <= req_nxt;
    end
  end

  p_req_sticky_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !clr_i) |=> req_o);
endmodule

// File: rtl/stx_evt_reg.sv
module stx_evt_reg
  import stx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done_d_i,
  input  logic               abort_d_i,
  input  logic [CAUSE_W-1:0] cause_d_i,
  output logic               done_o,
  output logic               abort_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic evt_en;

  assign evt_en = done_d_i | abort_d_i | done_o | abort_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      cause_o <= '0;
    end else if (evt_en) begin
      done_o  <= done_d_i;
      abort_o <= abort_d_i;
      cause_o <= abort_d_i ? cause_d_i : '0;
    end
  end

  p_cause_with_abort_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (cause_o != '0));

  p_no_stray_cause_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !abort_o |-> (cause_o == '0));

  p_done_abort_excl_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && abort_o));

  p_arb_pair_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o && cause_o[CZ_SLV_LOST]) |-> cause_o[CZ_ARB_LOST]);
endmodule

// File: rtl/stx_slave_tx.sv
module stx_slave_tx
  import stx_pkg::*;
#(
  parameter int  DATA_W     = 8,
  parameter int  FIFO_DEPTH = 8,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_hit_i,
  input  logic [LVL_W-1:0]   fifo_level_i,
  input  logic [DATA_W-1:0]  fifo_data_i,
  input  logic               fifo_cmd_i,
  input  logic               byte_done_i,
  input  logic               master_nack_i,
  input  logic               bus_end_i,
  input  logic               scl_rise_i,
  input  logic               sda_drive_i,
  input  logic               sda_in_i,
  input  logic               rd_req_clr_i,
  output logic               scl_hold_o,
  output logic               fifo_pop_o,
  output logic               fifo_flush_o,
  output logic               load_valid_o,
  output logic [DATA_W-1:0]  load_data_o,
  output logic               rd_req_o,
  output logic               done_o,
  output logic               abort_o,
  output logic [CAUSE_W-1:0] abort_cause_o,
  output logic               busy_o
);
  logic               req_set;
  logic               done_evt;
  logic               abort_evt;
  logic [CAUSE_W-1:0] cause_evt;

  stx_ctrl_fsm #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_hit_i     (rd_hit_i),
    .fifo_level_i (fifo_level_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_cmd_i   (fifo_cmd_i),
    .byte_done_i  (byte_done_i),
    .master_nack_i(master_nack_i),
    .bus_end_i    (bus_end_i),
    .scl_rise_i   (scl_rise_i),
    .sda_drive_i  (sda_drive_i),
    .sda_in_i     (sda_in_i),
    .scl_hold_o   (scl_hold_o),
    .req_set_o    (req_set),
    .fifo_pop_o   (fifo_pop_o),
    .fifo_flush_o (fifo_flush_o),
    .load_valid_o (load_valid_o),
    .load_data_o  (load_data_o),
    .done_evt_o   (done_evt),
    .abort_evt_o  (abort_evt),
    .cause_evt_o  (cause_evt),
    .busy_o       (busy_o)
  );

  stx_req_flag u_req (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(req_set),
    .clr_i(rd_req_clr_i),
    .req_o(rd_req_o)
  );

  stx_evt_reg u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_d_i (done_evt),
    .abort_d_i(abort_evt),
    .cause_d_i(cause_evt),
    .done_o   (done_o),
    .abort_o  (abort_o),
    .cause_o  (abort_cause_o)
  );

  p_hold_sets_req_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_o |=> rd_req_o);

  p_done_idle_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/stx_slave_tx_tb_top.sv
`timescale 1ns/1ps
module stx_slave_tx_tb_top;
  localparam int DATA_W = 8;
  localparam int LVL_W  = 4;

  logic clk;
  logic rst_n;
  logic rd_hit, byte_done, nack, bus_end, scl_rise, sda_drv, sda_in, req_clr;
  logic wr_en, wr_cmd;
  logic [DATA_W-1:0] wr_data;

  logic [LVL_W-1:0]  f_level;
  logic [DATA_W-1:0] f_data;
  logic              f_cmd;

  logic scl_hold, pop, flush, load_valid, rd_req, done, abort, busy;
  logic [DATA_W-1:0] load_data;
  logic [3:0] cause;

  int n_chk;
  int n_fail;
  logic [DATA_W-1:0] exp_q[$];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // transmit FIFO model
  logic [DATA_W:0] mem [0:15];
  logic [3:0] rp, wp;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; f_level <= '0;
    end else if (flush) begin
      rp <= wp; f_level <= '0;
    end else begin
      if (wr_en) begin
        mem[wp] <= {wr_cmd, wr_data};
        wp <= wp + 4'd1;
      end
      if (pop) rp <= rp + 4'd1;
      f_level <= f_level + {3'd0, wr_en} - {3'd0, pop};
    end
  end
  assign f_data = mem[rp][DATA_W-1:0];
  assign f_cmd  = mem[rp][DATA_W];

  stx_slave_tx dut_i (
    .clk(clk), .rst_n(rst_n), .rd_hit_i(rd_hit), .fifo_level_i(f_level),
    .fifo_data_i(f_data), .fifo_cmd_i(f_cmd), .byte_done_i(byte_done),
    .master_nack_i(nack), .bus_end_i(bus_end), .scl_rise_i(scl_rise),
    .sda_drive_i(sda_drv), .sda_in_i(sda_in), .rd_req_clr_i(req_clr),
    .scl_hold_o(scl_hold), .fifo_pop_o(pop), .fifo_flush_o(flush),
    .load_valid_o(load_valid), .load_data_o(load_data), .rd_req_o(rd_req),
    .done_o(done), .abort_o(abort), .abort_cause_o(cause), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor: every byte handed to the engine must be the next expected one (R4)
  always @(negedge clk) begin
    if (rst_n && load_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected load", int'(load_data), 0);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        check(load_data == e, "R4", "load_data order", int'(load_data), int'(e));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic hit();
    @(posedge clk); #2 rd_hit = 1'b1;
    @(posedge clk); #2 rd_hit = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic c, input bit expect_send);
    @(posedge clk); #2 wr_en = 1'b1; wr_data = d; wr_cmd = c;
    if (expect_send) exp_q.push_back(d);
    @(posedge clk); #2 wr_en = 1'b0;
  endtask

  task automatic clr_req();
    @(posedge clk); #2 req_clr = 1'b1;
    @(posedge clk); #2 req_clr = 1'b0;
  endtask

  task automatic ack(input logic nk);
    @(posedge clk); #2 byte_done = 1'b1; nack = nk;
    @(posedge clk); #2 byte_done = 1'b0; nack = 1'b0;
  endtask

  task automatic rise(input logic drv, input logic smp);
    @(posedge clk); #2 scl_rise = 1'b1; sda_drv = drv; sda_in = smp;
    @(posedge clk); #2 scl_rise = 1'b0;
  endtask

  task automatic stop_bus();
    @(posedge clk); #2 bus_end = 1'b1;
    @(posedge clk); #2 bus_end = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    finish_test();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; rd_hit = 0; byte_done = 0; nack = 0; bus_end = 0;
    scl_rise = 0; sda_drv = 0; sda_in = 0; req_clr = 0;
    wr_en = 0; wr_cmd = 0; wr_data = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    check(scl_hold == 0 && rd_req == 0 && busy == 0, "R1", "hold/req/busy", {scl_hold, rd_req, busy}, 0);
    check(pop == 0 && flush == 0 && load_valid == 0 && done == 0 && abort == 0, "R1", "pulses",
          {pop, flush, load_valid, done, abort}, 0);

    // ---- streaming transfer ----
    hit();
    check(scl_hold == 1, "R2", "scl_hold on empty", scl_hold, 1);
    step(1);
    check(rd_req == 1, "R2", "rd_req raised", rd_req, 1);
    step(4);
    check(rd_req == 1 && scl_hold == 1, "R3", "request held while empty", {rd_req, scl_hold}, 3);
    push(8'hA1, 1'b0, 1);
    step(1);
    check(rd_req == 1, "R3", "write does not clear rd_req", rd_req, 1);
    check(scl_hold == 0, "R4", "hold released in send", scl_hold, 0);
    clr_req();
    check(rd_req == 0, "R3", "rd_req cleared by software", rd_req, 0);
    push(8'hA2, 1'b0, 1);
    push(8'hA3, 1'b0, 1);
    ack(1'b0);
    check(scl_hold == 0, "R4", "no hold with data", scl_hold, 0);
    step(1);
    check(rd_req == 0, "R4", "no new request back-to-back", rd_req, 0);
    ack(1'b0);
    step(1);
    check(rd_req == 0 && scl_hold == 0, "R4", "third byte back-to-back", {rd_req, scl_hold}, 0);
    ack(1'b0);
    check(scl_hold == 1, "R2", "hold after last ACK", scl_hold, 1);
    step(1);
    check(rd_req == 1, "R2", "request after FIFO drained", rd_req, 1);
    push(8'hA4, 1'b0, 1);
    clr_req();
    step(1);
    ack(1'b1);
    check(done == 1 && busy == 0, "R6", "done on NACK", {done, busy}, 2);
    check(abort == 0, "R10", "no abort with done", abort, 0);
    step(1);
    check(done == 0, "R10", "done lasts one cycle", done, 0);
    check(exp_q.size() == 0, "R4", "all bytes sent", exp_q.size(), 0);

    // ---- NACK with surplus bytes ----
    hit();
    step(1);
    push(8'hB1, 1'b0, 1);
    push(8'hB2, 1'b0, 0);
    push(8'hB3, 1'b0, 0);
    clr_req();
    check(f_level == 2, "R6", "surplus waiting", f_level, 2);
    ack(1'b1);
    check(done == 1, "R6", "done with surplus", done, 1);
    check(f_level == 0, "R6", "surplus discarded", f_level, 0);
    check(busy == 0, "R6", "idle after done", busy, 0);

    // ---- stale data at address time ----
    push(8'hC1, 1'b0, 0);
    push(8'hC2, 1'b0, 0);
    step(2);
    check(busy == 0 && f_level == 2, "R5", "idle keeps FIFO", {busy, f_level}, 2);
    hit();
    check(abort == 1 && cause == 4'b0001, "R5", "stale abort cause", {abort, cause}, 5'h11);
    check(f_level == 0 && busy == 1, "R5", "flushed and continuing", {f_level, busy}, 1);
    step(1);
    check(abort == 0 && cause == 0, "R10", "abort lasts one cycle", {abort, cause}, 0);
    check(rd_req == 1, "R5", "request after stale flush", rd_req, 1);

    // ---- read command in transmit data ----
    push(8'hD1, 1'b1, 0);
    step(1);
    check(abort == 1 && cause == 4'b0010, "R7", "read-command abort", {abort, cause}, 5'h12);
    check(busy == 0 && f_level == 0, "R7", "flushed and idle", {busy, f_level}, 0);
    clr_req();

    // ---- bus mismatch ----
    hit();
    push(8'hE1, 1'b0, 1);
    clr_req();
    step(1);
    rise(1'b1, 1'b1);
    check(abort == 0 && busy == 1, "R8", "matching bit ignored", {abort, busy}, 1);
    rise(1'b1, 1'b0);
    check(abort == 1 && cause == 4'b1100, "R8", "mismatch abort", {abort, cause}, 5'h1C);
    check(busy == 0, "R8", "idle after mismatch", busy, 0);

    // ---- STOP in mid transfer ----
    hit();
    push(8'hF1, 1'b0, 1);
    clr_req();
    step(1);
    push(8'hF2, 1'b0, 0);
    stop_bus();
    check(busy == 0 && f_level == 0, "R9", "stop ends and flushes", {busy, f_level}, 0);
    check(done == 0 && abort == 0, "R9", "no done/abort on stop", {done, abort}, 0);
    step(2);
    check(done == 0 && abort == 0 && load_valid == 0, "R9", "quiet after stop",
          {done, abort, load_valid}, 0);
    check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);

    finish_test();
  end
endmodule